// File: doc/BRIEF.md
# Clock Ratio Burst Converter

This block lets a processor that divides its input clock by sixteen (or fifteen) run from a board reference clock meant for a processor that divides by twelve, while keeping the same bus rate. It runs on a fast system clock and watches a slower reference clock. For every window of twelve reference clock cycles, it sends one burst of fast output pulses to the processor's clock pin. The pulse period is three system clock cycles. The processor's internal divider then produces one bus cycle per twelve reference cycles, just as the divide-by-twelve part would.

The burst length is set by a select input: sixteen pulses by default, or fifteen. After the last pulse of a burst, the output stays low for the rest of the window. Each new burst therefore starts in a fixed phase relation to the reference clock. The reference input is asynchronous to the system clock and is synchronized inside the block. A one-cycle strobe marks the start of each window.

Top module: `burst_clk_conv`

## Requirements
- R1: A window spans exactly twelve rising edges of the reference clock. `win_start` is high for exactly one system cycle, in the third system cycle after the reference rising edge that completes the window. That is two cycles for the synchronizer plus one for the counter.
- R2: With `burst_sel` = 0 latched at a window start, the window contains exactly sixteen output pulses.
- R3: With `burst_sel` = 1 latched at a window start, the window contains exactly fifteen output pulses.
- R4: Each output pulse is high for one system cycle and low for two, so pulses repeat every three system cycles. The first pulse of a burst is high in the system cycle right after `win_start`.
- R5: Once the selected number of pulses has been sent, `burst_clk` stays low until the next `win_start`.
- R6: `burst_sel` is sampled only on the clock edge that ends the `win_start` cycle. Changes at any other time do not alter the burst in progress.
- R7: While reset is active, and after it until the first `win_start`, both outputs are low. The first `win_start` after reset follows the twelfth reference rising edge seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast system clock (100 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_in | input | 1 | Asynchronous reference clock (about 21.48 MHz) |
| burst_sel | input | 1 | Burst length select: 0 gives sixteen pulses, 1 gives fifteen |
| burst_clk | output | 1 | Gated burst clock to the processor |
| win_start | output | 1 | One-cycle strobe at the start of each window |

## Verification
The reference clock is swept over several periods, from four to nine system cycles. The shortest period makes the burst fill the whole window, so an off-by-one in pulse spacing or burst length shows up as an overlap. The longer periods leave idle gaps in which a stray pulse would be seen. Each period is run with the select held at zero, held at one, and toggling in the middle of windows. The held cases separate the two burst lengths. The toggling case shows whether the select is sampled at the window boundary only. A reset in the middle of a burst, followed by a fresh count of twelve reference edges, checks that the block silences its output and restarts its window count from zero.

// File: rtl/burst_conv_pkg.sv
package burst_conv_pkg;

   // Width needed to hold values 0..n
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bcc_ref_sync.sv
module bcc_ref_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_async,
   output logic ref_rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bcc_ref_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;
   logic              prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sr[0] <= 1'b0;
               else        sr[0] <= ref_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sr[i] <= 1'b0;
               else        sr[i] <= sr[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= sr[STAGES-1];
   end

   assign ref_rise = sr[STAGES-1] & ~prev;

   // A detected edge can never last two cycles
   assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ref_rise |=> !ref_rise);

endmodule

// File: rtl/bcc_window_ctr.sv
module bcc_window_ctr #(
   parameter int EDGES = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_rise,
   output logic win_start
);
   import burst_conv_pkg::*;

   localparam int EW = cnt_width(EDGES - 1);

   generate
      if (EDGES < 2) begin : g_bad_edges
         $error("bcc_window_ctr: EDGES must be at least 2");
      end
   endgenerate

   logic [EW-1:0] edge_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         edge_cnt  <= '0;
         win_start <= 1'b0;
      end else begin
         win_start <= 1'b0;
         if (ref_rise) begin
            if (edge_cnt == EW'(EDGES - 1)) begin
               edge_cnt  <= '0;
               win_start <= 1'b1;
            end else begin
               edge_cnt <= edge_cnt + 1'b1;
            end
         end
      end
   end

   assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      edge_cnt <= EW'(EDGES - 1));

   assert_strobe_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
      win_start |=> !win_start);

   assert_strobe_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_start) |-> $past(ref_rise));

endmodule

// File: rtl/bcc_burst_gen.sv
module bcc_burst_gen #(
   parameter int DIV     = 3,
   parameter int LONG_N  = 16,
   parameter int SHORT_N = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic win_start,
   input  logic burst_sel,
   output logic burst_clk
);
   import burst_conv_pkg::*;

   localparam int PW = cnt_width(DIV - 1);
   localparam int CW = cnt_width(max2(LONG_N, SHORT_N));

   generate
      if (DIV < 2) begin : g_bad_div
         $error("bcc_burst_gen: DIV must be at least 2");
      end
      if (LONG_N < 1 || SHORT_N < 1) begin : g_bad_len
         $error("bcc_burst_gen: burst lengths must be positive");
      end
   endgenerate

   logic          active;
   logic [PW-1:0] phase;
   logic [CW-1:0] pcnt;
   logic [CW-1:0] tgt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= '0;
         pcnt   <= '0;
         tgt    <= CW'(LONG_N);
      end else if (win_start) begin
         active <= 1'b1;
         phase  <= '0;
         pcnt   <= '0;
         tgt    <= burst_sel ? CW'(SHORT_N) : CW'(LONG_N);
      end else if (active) begin
         if (phase == PW'(DIV - 1)) begin
            phase <= '0;
            pcnt  <= pcnt + 1'b1;
            if (pcnt == tgt - 1'b1) active <= 1'b0;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   assign burst_clk = active && (phase == '0);

   assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      burst_clk |=> !burst_clk);

   assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= tgt);

   assert_idle_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !win_start) |=> !burst_clk);

   assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !win_start |=> $stable(tgt));

endmodule

// File: rtl/burst_clk_conv.sv
module burst_clk_conv #(
   parameter int SYNC_STAGES  = 2,
   parameter int WINDOW_EDGES = 12,
   parameter int CLK_DIV      = 3,
   parameter int LONG_BURST   = 16,
   parameter int SHORT_BURST  = 15
) (
   input  logic clk_sys,
   input  logic rst_n,
   input  logic ref_clk_in,
   input  logic burst_sel,
   output logic burst_clk,
   output logic win_start
);

   logic ref_rise;

   bcc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk_sys),
      .rst_n     (rst_n),
      .ref_async (ref_clk_in),
      .ref_rise  (ref_rise)
   );

   bcc_window_ctr #(.EDGES(WINDOW_EDGES)) u_win (
      .clk       (clk_sys),
      .rst_n     (rst_n),
      .ref_rise  (ref_rise),
      .win_start (win_start)
   );

   bcc_burst_gen #(
      .DIV     (CLK_DIV),
      .LONG_N  (LONG_BURST),
      .SHORT_N (SHORT_BURST)
   ) u_burst (
      .clk       (clk_sys),
      .rst_n     (rst_n),
      .win_start (win_start),
      .burst_sel (burst_sel),
      .burst_clk (burst_clk)
   );

   // R7: no output activity while reset is held
   assert_reset_quiet_R7: assert property (@(posedge clk_sys)
      !rst_n |=> (!burst_clk && !win_start));

endmodule

// File: tb/sim_burst_clk_conv.sv
module sim_burst_clk_conv;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_in = 1'b0;
   logic sel = 1'b0;
   logic burst_clk, win_start;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_clk_conv u0 (
      .clk_sys    (clk),
      .rst_n      (rst_n),
      .ref_clk_in (ref_in),
      .burst_sel  (sel),
      .burst_clk  (burst_clk),
      .win_start  (win_start)
   );

   int checks = 0;
   int failures = 0;

   int cyc = 0;
   int last_rise = -100;
   int rises = 0;
   bit in_win = 0;
   int win_cyc = 0;
   int pulses = 0;
   int last_pulse = 0;
   int exp_n = 16;
   bit prev_b = 0;
   bit prev_w = 0;
   bit pend_win = 0;
   int sel_mode = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // One system cycle: sample at negedge, then drive new inputs
   task automatic tick(input logic ref_v);
      @(negedge clk);
      cyc++;
      pend_win = 0;
      if (rst_n) begin
         if (!in_win) begin
            if (burst_clk || win_start === 1'b0) ; // handled below
            if (burst_clk) chk(0, "R7 pulse before first window", 1, 0);
         end
         if (burst_clk && prev_b) chk(0, "R4 pulse high two cycles", 1, 0);
         if (burst_clk && in_win) begin
            if (pulses == 0) chk(cyc == win_cyc + 1, "R4 first pulse offset", cyc - win_cyc, 1);
            else             chk(cyc == last_pulse + 3, "R4 pulse spacing", cyc - last_pulse, 3);
            pulses++;
            last_pulse = cyc;
            if (pulses > exp_n) chk(0, "R5 extra pulse after burst", pulses, exp_n);
         end
         if (win_start) begin
            chk(!prev_w, "R1 strobe width", 2, 1);
            chk(rises == 12, "R1 rises per window", rises, 12);
            chk(last_rise == cyc - 3, "R1 strobe latency", cyc - last_rise, 3);
            if (in_win) begin
               if (exp_n == 16) chk(pulses == 16, "R2 pulses with sel=0", pulses, 16);
               else             chk(pulses == 15, "R3 pulses with sel=1", pulses, 15);
            end
            pend_win = 1;
            rises = 0;
         end
         prev_b = burst_clk;
         prev_w = win_start;
      end
      // drive
      if (ref_v && !ref_in && rst_n) begin
         rises++;
         last_rise = cyc;
      end
      ref_in = ref_v;
      case (sel_mode)
         0: sel = 1'b0;
         1: sel = 1'b1;
         default: sel = ((cyc / 7) % 2) == 1; // R6: toggles mid-window
      endcase
      if (pend_win) begin
         exp_n = sel ? 15 : 16; // value present at the sampling edge (R6)
         win_cyc = cyc;
         pulses = 0;
         in_win = 1;
      end
   endtask

   task automatic run_ref(input int period, input int n_edges);
      for (int e = 0; e < n_edges; e++) begin
         for (int k = 0; k < period; k++) tick(k < period / 2 ? 1'b1 : 1'b0);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ref_in = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         cyc++;
         chk(!burst_clk && !win_start, "R7 outputs low in reset", burst_clk + win_start, 0);
      end
      rst_n = 1'b1;
      rises = 0;
      in_win = 0;
      prev_b = 0;
      prev_w = 0;
      pulses = 0;
   endtask

   initial begin
      #(CLK_PERIOD * WD_CYCLES);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   int wins_seen;
   initial begin
      do_reset();
      // R7: eleven edges give no window and no pulse
      sel_mode = 0;
      wins_seen = 0;
      for (int e = 0; e < 11; e++) begin
         for (int k = 0; k < 6; k++) begin
            tick(k < 3 ? 1'b1 : 1'b0);
            if (win_start) wins_seen++;
         end
      end
      chk(wins_seen == 0, "R7 no window before twelfth edge", wins_seen, 0);
      run_ref(6, 13);
      chk(in_win, "R7 first window after twelve edges", in_win, 1);

      // Sweep reference periods and select modes (R2, R3, R4, R5, R6)
      for (int m = 0; m < 3; m++) begin
         sel_mode = m;
         for (int p = 4; p <= 9; p++) begin
            if (p == 8) continue;
            run_ref(p, 12 * 5);
         end
      end

      // Reset in the middle of a burst, then restart (R7)
      sel_mode = 0;
      run_ref(5, 12);
      for (int k = 0; k < 10; k++) tick(k % 5 < 2);
      do_reset();
      run_ref(7, 12 * 4);
      chk(in_win, "R7 window after mid-burst reset", in_win, 1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule